// File: doc/BRIEF.md
# Way-Locking Victim Selector

This block chooses which way of a four-way set-associative data cache receives a new line when an access misses. A small control word decides whether lock mode is on and, for the two upper ways (2 and 3), whether each is protected from ordinary replacement and whether prefetch misses are sent into it. Software uses this to pin a block of data in way 2 or way 3. It prefetches the data into the chosen way, and ordinary misses then never evict it.

Each cycle the cache presents an access flag, a hit flag, a prefetch flag, the per-way valid bits of the addressed set and that set's 6-bit pairwise age vector. The block answers in the same cycle with a fill-enable and a victim way number. Out of lock mode it uses the plain policy over all four ways. That policy takes the lowest-numbered invalid way first and otherwise the least recently used way. Tag compare, data storage, line fetching and age updates belong to the surrounding cache.

Two resets act on the block. A power-on reset clears everything. A warm reset clears only the misuse flag and leaves the control word as it was.

Top module: `way_victim_sel`

## Requirements
- R1: The control word holds five writable bits: lock enable at bit 16, way-3 load at bit 9, way-3 lock at bit 8, way-2 load at bit 1 and way-2 lock at bit 0. Every other bit ignores writes and reads as zero, so writing all ones reads back 0x00010303.
- R2: With lock enable at 0, the load and lock bits change nothing, and the victim is chosen over all four ways by the plain policy.
- R3: With lock enable at 1, a prefetch miss fills way 3 when way-3 load is set. When only way-2 load is set, it fills way 2. This holds whatever the valid bits and age vector say.
- R4: An access that hits raises no fill, whether or not it is a prefetch and whichever way holds the line.
- R5: With lock enable at 1, a non-prefetch miss never picks way 3 while way-3 lock is set, and never picks way 2 while way-2 lock is set.
- R6: The plain policy takes the lowest-numbered way that is both invalid and eligible.
- R7: When every eligible way is valid, the plain policy takes the eligible way that is older than every other eligible way. Age bit k covers the pair (0,1),(0,2),(0,3),(1,2),(1,3),(2,3) for k=0..5 in that order. A 1 means the lower-numbered way of the pair was used more recently. If no eligible way is oldest, the lowest eligible way is taken.
- R8: A write that sets both load bits raises a sticky misuse flag. While both load bits are set, a lock-mode prefetch miss goes to way 3.
- R9: In lock mode, a prefetch miss with neither load bit set uses the plain policy, and locked ways stay excluded.
- R10: Power-on reset clears the control word and the misuse flag. Warm reset (active low, sampled at the clock edge) clears only the misuse flag and keeps the control word.
- R11: The fill-enable and the victim are combinational from the access inputs and are valid in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst_n | input | 1 | Power-on / deep-standby reset, asynchronous, active low |
| warm_rst_n | input | 1 | Warm reset, synchronous, active low |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Control word read value |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_hit | input | 1 | The access hit in some way |
| acc_pref | input | 1 | The access is a prefetch |
| set_valid | input | 4 | Valid bit of each way in the addressed set |
| set_age | input | 6 | Pairwise age vector of the addressed set |
| fill_en | output | 1 | A line fill is required |
| victim_way | output | 2 | Way to be replaced |
| load_conflict | output | 1 | Sticky flag: both load bits were written as 1 |

## Verification
A wrong lock or eligibility mask shows up on the victim port as soon as a miss lands on a locked way, in the same cycle the miss is presented. The bench therefore sweeps all 32 control settings against a mix of valid and age patterns. A corrupted control bit is visible at once on the read port, and after any write on the next cycle. A misuse flag that is set or cleared wrongly appears one edge after the write or warm reset that should have moved it.

// File: rtl/way_lock_pkg.sv
package way_lock_pkg;

  localparam int NWAYS = 4;
  localparam int WAY_W = $clog2(NWAYS);
  localparam int AGE_W = NWAYS * (NWAYS - 1) / 2;
  localparam int CFG_W = 32;

  localparam int BIT_LE  = 16;
  localparam int BIT_LD3 = 9;
  localparam int BIT_LK3 = 8;
  localparam int BIT_LD2 = 1;
  localparam int BIT_LK2 = 0;

  localparam logic [CFG_W-1:0] CFG_MASK =
    (CFG_W'(1) << BIT_LE)  | (CFG_W'(1) << BIT_LD3) | (CFG_W'(1) << BIT_LK3) |
    (CFG_W'(1) << BIT_LD2) | (CFG_W'(1) << BIT_LK2);

  typedef struct packed {
    logic le;
    logic ld3;
    logic lk3;
    logic ld2;
    logic lk2;
  } lock_cfg_t;

  // Bit index of the pair (a,b), a < b, in the age vector.
  function automatic int pair_bit(input int a, input int b);
    return a * (2 * NWAYS - a - 1) / 2 + (b - a - 1);
  endfunction

  // True when way a was used less recently than way b.
  function automatic logic is_older(input logic [AGE_W-1:0] age,
                                    input int a, input int b);
    if (a < b) return ~age[pair_bit(a, b)];
    else       return age[pair_bit(b, a)];
  endfunction

  // Index of the lowest set bit; 0 when the mask is empty.
  function automatic logic [WAY_W-1:0] lowest_set(input logic [NWAYS-1:0] m);
    logic [WAY_W-1:0] idx;
    idx = '0;
    for (int i = NWAYS - 1; i >= 0; i--)
      if (m[i]) idx = WAY_W'(i);
    return idx;
  endfunction

endpackage

// File: rtl/wl_cfg_reg.sv
module wl_cfg_reg
  import way_lock_pkg::*;
(
  input  logic             clk,
  input  logic             por_rst_n,
  input  logic             warm_rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] rdata,
  output lock_cfg_t        cfg,
  output logic             conflict
);
  logic [CFG_W-1:0] reg_q;
  logic             conflict_q;
  logic             both_loads_wr;

  assign both_loads_wr = wdata[BIT_LD3] & wdata[BIT_LD2];

  always_ff @(posedge clk or negedge por_rst_n) begin
    if (!por_rst_n) begin
      reg_q      <= '0;
      conflict_q <= 1'b0;
    end else begin
      if (we) reg_q <= wdata & CFG_MASK;
      if (!warm_rst_n)                conflict_q <= 1'b0;
      else if (we && both_loads_wr)   conflict_q <= 1'b1;
    end
  end

  assign rdata    = reg_q;
  assign conflict = conflict_q;
  assign cfg.le   = reg_q[BIT_LE];
  assign cfg.ld3  = reg_q[BIT_LD3];
  assign cfg.lk3  = reg_q[BIT_LK3];
  assign cfg.ld2  = reg_q[BIT_LD2];
  assign cfg.lk2  = reg_q[BIT_LK2];
endmodule

// File: rtl/wl_elig.sv
module wl_elig
  import way_lock_pkg::*;
(
  input  lock_cfg_t        cfg,
  output logic [NWAYS-1:0] lock_mask
);
  always_comb begin
    lock_mask = '0;
    if (cfg.le) begin
      lock_mask[3] = cfg.lk3;
      lock_mask[2] = cfg.lk2;
    end
  end
endmodule

// File: rtl/wl_pick.sv
module wl_pick
  import way_lock_pkg::*;
(
  input  logic [AGE_W-1:0] age,
  input  logic [NWAYS-1:0] valid,
  input  logic [NWAYS-1:0] elig,
  output logic [WAY_W-1:0] victim,
  output logic             took_invalid
);
  logic [NWAYS-1:0] inv_cand;
  logic [NWAYS-1:0] oldest;

  assign inv_cand = elig & ~valid;

  for (genvar w = 0; w < NWAYS; w++) begin : g_way
    logic lru_here;
    always_comb begin
      lru_here = elig[w];
      for (int v = 0; v < NWAYS; v++)
        if (v != w && elig[v] && !is_older(age, w, v)) lru_here = 1'b0;
    end
    assign oldest[w] = lru_here;
  end

  assign took_invalid = |inv_cand;

  always_comb begin
    if (took_invalid)  victim = lowest_set(inv_cand);
    else if (|oldest)  victim = lowest_set(oldest);
    else               victim = lowest_set(elig);
  end
endmodule

// File: rtl/way_victim_sel.sv
module way_victim_sel
  import way_lock_pkg::*;
(
  input  logic        clk,
  input  logic        por_rst_n,
  input  logic        warm_rst_n,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        acc_valid,
  input  logic        acc_hit,
  input  logic        acc_pref,
  input  logic [3:0]  set_valid,
  input  logic [5:0]  set_age,
  output logic        fill_en,
  output logic [1:0]  victim_way,
  output logic        load_conflict
);
  lock_cfg_t        cfg;
  logic [NWAYS-1:0] lock_mask;
  logic [NWAYS-1:0] elig;
  logic [WAY_W-1:0] plain_victim;
  logic             took_invalid;
  logic             steer_w3;
  logic             steer_w2;
  logic             miss;

  wl_cfg_reg u_cfg (
    .clk(clk), .por_rst_n(por_rst_n), .warm_rst_n(warm_rst_n),
    .we(cfg_we), .wdata(cfg_wdata), .rdata(cfg_rdata),
    .cfg(cfg), .conflict(load_conflict)
  );

  wl_elig u_elig (.cfg(cfg), .lock_mask(lock_mask));

  assign elig = ~lock_mask;

  wl_pick u_pick (
    .age(set_age), .valid(set_valid), .elig(elig),
    .victim(plain_victim), .took_invalid(took_invalid)
  );

  assign miss     = acc_valid & ~acc_hit;
  assign steer_w3 = cfg.le & acc_pref & cfg.ld3;
  assign steer_w2 = cfg.le & acc_pref & ~cfg.ld3 & cfg.ld2;

  assign fill_en = miss;

  always_comb begin
    if (steer_w3)      victim_way = 2'd3;
    else if (steer_w2) victim_way = 2'd2;
    else               victim_way = plain_victim;
  end
endmodule

// File: rtl/way_victim_sel_chk.sv
module way_victim_sel_chk (
  input logic        clk,
  input logic        por_rst_n,
  input logic        warm_rst_n,
  input logic        cfg_we,
  input logic [31:0] cfg_wdata,
  input logic [31:0] cfg_rdata,
  input logic        acc_valid,
  input logic        acc_hit,
  input logic        acc_pref,
  input logic [3:0]  set_valid,
  input logic        fill_en,
  input logic [1:0]  victim_way,
  input logic        load_conflict,
  input logic        took_invalid
);
  logic le, ld3, lk3, ld2, lk2;
  assign le  = cfg_rdata[16];
  assign ld3 = cfg_rdata[9];
  assign lk3 = cfg_rdata[8];
  assign ld2 = cfg_rdata[1];
  assign lk2 = cfg_rdata[0];

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!por_rst_n)
    (cfg_rdata & ~32'h0001_0303) == 32'h0) else $error("reserved bits set"); // R1
  AST_W3_STEER: assert property (@(posedge clk) disable iff (!por_rst_n)
    (fill_en && acc_pref && le && ld3) |-> victim_way == 2'd3) else $error("w3 steer"); // R3
  AST_HIT_NO_FILL: assert property (@(posedge clk) disable iff (!por_rst_n)
    (acc_valid && acc_hit) |-> !fill_en) else $error("fill on hit"); // R4
  AST_LOCK3_HONOURED: assert property (@(posedge clk) disable iff (!por_rst_n)
    (fill_en && !acc_pref && le && lk3) |-> victim_way != 2'd3) else $error("lk3 evicted"); // R5
  AST_LOCK2_HONOURED: assert property (@(posedge clk) disable iff (!por_rst_n)
    (fill_en && !acc_pref && le && lk2) |-> victim_way != 2'd2) else $error("lk2 evicted"); // R5
  AST_INVALID_PICKED: assert property (@(posedge clk) disable iff (!por_rst_n)
    (fill_en && !acc_pref && took_invalid) |-> !set_valid[victim_way]) else $error("valid way taken"); // R6
  AST_CONFLICT_SET: assert property (@(posedge clk) disable iff (!por_rst_n)
    (cfg_we && cfg_wdata[9] && cfg_wdata[1] && warm_rst_n) |=> load_conflict) else $error("flag not set"); // R8
  AST_CONFLICT_STICKY: assert property (@(posedge clk) disable iff (!por_rst_n)
    (load_conflict && warm_rst_n) |=> load_conflict) else $error("flag dropped"); // R8
  AST_WARM_KEEPS_CFG: assert property (@(posedge clk) disable iff (!por_rst_n)
    (!warm_rst_n && !cfg_we) |=> $stable(cfg_rdata)) else $error("cfg lost on warm reset"); // R10
endmodule

bind way_victim_sel way_victim_sel_chk chk_i (
  .clk(clk), .por_rst_n(por_rst_n), .warm_rst_n(warm_rst_n),
  .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
  .acc_valid(acc_valid), .acc_hit(acc_hit), .acc_pref(acc_pref),
  .set_valid(set_valid), .fill_en(fill_en), .victim_way(victim_way),
  .load_conflict(load_conflict), .took_invalid(took_invalid)
);

// File: tb/way_victim_sel_tb_top.sv
module way_victim_sel_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        por_rst_n = 1'b0;
  logic        warm_rst_n = 1'b1;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        acc_valid = 1'b0;
  logic        acc_hit = 1'b0;
  logic        acc_pref = 1'b0;
  logic [3:0]  set_valid = '0;
  logic [5:0]  set_age = '0;
  logic        fill_en;
  logic [1:0]  victim_way;
  logic        load_conflict;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  way_victim_sel dut_i (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Age bit index of pair (lo,hi): order (0,1),(0,2),(0,3),(1,2),(1,3),(2,3).
  function automatic int pidx(input int lo, input int hi);
    case ({lo[1:0], hi[1:0]})
      4'b0001: return 0;  4'b0010: return 1;  4'b0011: return 2;
      4'b0110: return 3;  4'b0111: return 4;  default: return 5;
    endcase
  endfunction

  function automatic bit older(input logic [5:0] age, input int w, input int v);
    int lo, hi;
    lo = (w < v) ? w : v;
    hi = (w < v) ? v : w;
    // bit = 1: lower-numbered way used more recently
    return (w == lo) ? !age[pidx(lo, hi)] : age[pidx(lo, hi)];
  endfunction

  function automatic logic [1:0] ref_victim(input bit le, ld3, lk3, ld2, lk2, pref,
                                            input logic [3:0] vld, input logic [5:0] age);
    bit [3:0] ok;
    if (le && pref && ld3) return 2'd3;
    if (le && pref && ld2) return 2'd2;
    ok = 4'hF;
    if (le && lk3) ok[3] = 1'b0;
    if (le && lk2) ok[2] = 1'b0;
    for (int w = 0; w < 4; w++) if (ok[w] && !vld[w]) return 2'(w);
    for (int w = 0; w < 4; w++) begin
      int cnt, tot;
      cnt = 0; tot = 0;
      if (!ok[w]) continue;
      for (int v = 0; v < 4; v++)
        if (v != w && ok[v]) begin tot++; if (older(age, w, v)) cnt++; end
      if (cnt == tot) return 2'(w);
    end
    for (int w = 0; w < 4; w++) if (ok[w]) return 2'(w);
    return 2'd0;
  endfunction

  task automatic write_cfg(input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  task automatic do_por;
    @(negedge clk); por_rst_n = 1'b0;
    @(negedge clk); por_rst_n = 1'b1;
  endtask

  task automatic apply(input bit v, h, p, input logic [3:0] vld, input logic [5:0] age);
    @(negedge clk);
    acc_valid = v; acc_hit = h; acc_pref = p; set_valid = vld; set_age = age;
    #1;
  endtask

  task automatic t_reset_state;
    do_por();
    #1;
    check("R10 por cfg", cfg_rdata, 32'h0);
    check("R10 por flag", {31'b0, load_conflict}, 32'h0);
  endtask

  task automatic t_reg_fields;
    write_cfg(32'hFFFF_FFFF); #1;
    check("R1 all ones", cfg_rdata, 32'h0001_0303);
    write_cfg(32'hFFFE_FCFC); #1;
    check("R1 reserved only", cfg_rdata, 32'h0);
    write_cfg(32'h0001_0100); #1;
    check("R1 le+lk3", cfg_rdata, 32'h0001_0100);
  endtask

  // R2 R3 R5 R6 R7 R9 R11: every control setting against valid/age patterns
  task automatic t_sweep;
    logic [3:0] vpat [5] = '{4'hF, 4'b1011, 4'b0111, 4'b1110, 4'b0000};
    for (int c = 0; c < 32; c++) begin
      bit le, ld3, lk3, ld2, lk2;
      {le, ld3, lk3, ld2, lk2} = 5'(c);
      do_por();
      write_cfg({15'b0, le, 6'b0, ld3, lk3, 6'b0, ld2, lk2});
      for (int p = 0; p < 2; p++) begin
        for (int a = 0; a < 64; a++) begin
          apply(1'b1, 1'b0, p[0], 4'hF, 6'(a));
          check(le ? (p[0] ? "R3/R9 lock pref" : "R5/R7 lock plain") : "R2/R7 unlocked",
                {30'b0, victim_way}, {30'b0, ref_victim(le, ld3, lk3, ld2, lk2, p[0], 4'hF, 6'(a))});
        end
        for (int k = 1; k < 5; k++) begin
          apply(1'b1, 1'b0, p[0], vpat[k], 6'b010101);
          check("R6 invalid first", {30'b0, victim_way},
                {30'b0, ref_victim(le, ld3, lk3, ld2, lk2, p[0], vpat[k], 6'b010101)});
          check("R11 fill same cycle", {31'b0, fill_en}, 32'h1);
        end
      end
    end
    apply(1'b0, 1'b0, 1'b0, 4'hF, 6'b0);
  endtask

  task automatic t_hits;
    do_por();
    write_cfg(32'h0001_0300);
    apply(1'b1, 1'b1, 1'b1, 4'hF, 6'b0);
    check("R4 pref hit other way", {31'b0, fill_en}, 32'h0);
    apply(1'b1, 1'b1, 1'b0, 4'h1, 6'h3F);
    check("R4 plain hit", {31'b0, fill_en}, 32'h0);
    apply(1'b1, 1'b0, 1'b1, 4'hF, 6'b0);
    check("R3 pref miss w3", {30'b0, victim_way}, 32'd3);
    apply(1'b0, 1'b0, 1'b0, 4'hF, 6'b0);
  endtask

  task automatic t_conflict;
    do_por();
    write_cfg(32'h0001_0202); #1;
    check("R8 flag set", {31'b0, load_conflict}, 32'h1);
    apply(1'b1, 1'b0, 1'b1, 4'h0, 6'b0);
    check("R8 w3 priority", {30'b0, victim_way}, 32'd3);
    write_cfg(32'h0); #1;
    check("R8 flag sticky", {31'b0, load_conflict}, 32'h1);
    apply(1'b0, 1'b0, 1'b0, 4'h0, 6'b0);
  endtask

  task automatic t_resets;
    do_por();
    write_cfg(32'h0001_0303);
    @(negedge clk); warm_rst_n = 1'b0;
    @(negedge clk); warm_rst_n = 1'b1; #1;
    check("R10 warm keeps cfg", cfg_rdata, 32'h0001_0303);
    check("R10 warm clears flag", {31'b0, load_conflict}, 32'h0);
    write_cfg(32'h0000_0202);
    do_por(); #1;
    check("R10 por clears cfg", cfg_rdata, 32'h0);
    check("R10 por clears flag", {31'b0, load_conflict}, 32'h0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    por_rst_n = 1'b1;
    t_reset_state();
    t_reg_fields();
    t_sweep();
    t_hits();
    t_conflict();
    t_resets();
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end
endmodule